// File: doc/BRIEF.md
# Cascadable Display-Controller Command Parser on a Two-Wire Bus

This block is the write-only two-wire (I2C) slave front end of a segment display controller meant to share one bus with several copies of itself. It oversamples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. It matches the address byte against a fixed six-bit prefix plus one strap-selected bit. It then splits the transfer into a chain of command bytes, followed by display data bytes that go into a 40-byte display RAM.

All copies that match the address acknowledge the address byte and every command byte together. Each copy keeps its own data pointer and "selected subaddress". During the data phase, only the copy whose three hardware subaddress pins equal the selected subaddress acknowledges and stores bytes. Every copy advances its pointer on every data byte. When the pointer passes the last RAM row, the selected subaddress steps on by one, so a long data run carries over into the next cascaded copy.

Each command byte leaves the block on a command stream. The bus cannot be stalled, so this stream has no ready: `cmd_valid` is a one-cycle beat and the sink must accept every beat. A combinational read port lets the display refresh logic fetch RAM rows.

Top module: `lcd_i2c_cmd_parser`

## Requirements
- R1: After synchronous reset the parser is idle, `sda_oe` and `cmd_valid` are low, and both the selected subaddress and the data pointer are 0, so the first data byte with no pointer command lands at row 0 of a device whose hardware subaddress is 0.
- R2: An address byte whose bits [7:1] equal 0111_00 followed by the `sa0_strap` value, and whose bit 0 (R/W) is 0, is acknowledged.
- R3: An address byte with the wrong SA0 bit, or with R/W = 1, is not acknowledged. The rest of that transfer is ignored: no ACK, no command beats and no RAM writes.
- R4: After a matching address, every command byte is acknowledged and is presented once on `cmd_byte` with a single-cycle `cmd_valid` pulse.
- R5: Bit 7 of a command byte is the continuation flag. When it is 1, the next byte is another command. When it is 0, the bytes that follow are display data.
- R6: A command with bits [6:5] = 11 and bits [4:3] = 10 loads the selected subaddress from bits [2:0]. Data bytes are acknowledged and stored only when `hw_sub` equals the selected subaddress.
- R7: A command with bits [6:5] = 00 loads the data pointer from bits [4:0].
- R8: A stored data byte is written at the current pointer, and the pointer then advances by one.
- R9: The pointer wraps from 39 to 0, and on that wrap the selected subaddress increments modulo 8.
- R10: A device that is not selected releases SDA for data bytes and leaves its RAM untouched, but still advances its pointer on each of them.
- R11: A repeated START aborts the current phase. The next byte is treated as an address byte, and after a match the byte after it is a command.
- R12: After STOP the parser ignores SCL activity until a new START.
- R13: `sda_oe` is asserted only from an SCL falling edge after bit 0 to the following SCL falling edge, and never while data bits are being clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | Pull SDA low (acknowledge) when 1 |
| sa0_strap | input | 1 | Strap that sets the low address bit |
| hw_sub | input | 3 | Hardware subaddress of this device in the cascade |
| cmd_valid | output | 1 | One-cycle beat: a command byte was received |
| cmd_byte | output | 8 | Command byte belonging to the beat |
| rd_addr | input | 6 | Display RAM read row |
| rd_data | output | 8 | Display RAM contents at `rd_addr` |

## Verification
The bench drives a command chain in which a continuation-flagged pointer load is followed by a second pointer load. A parser that ignored the flag would store the second command as data at row 10. The bench runs ten data bytes from row 30 through the wrap, then uses the same device with another strap value to show that the eleventh byte belonged to the next subaddress, at row 0 of that device's count. A design that forgot the subaddress step, or stalled the pointer, would acknowledge the eleventh byte or store the follow-up byte at the wrong row. Unselected data bytes are sent, and a later selected byte is checked at the advanced row; a design that stepped the pointer only when storing would misplace it. A repeated START in the middle of the data phase must turn the next bytes into address and command again, and clocks after STOP must draw no acknowledge.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
  localparam int SUB_W  = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_DATA,
    PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {
    SH_BITS,
    SH_WAITF,
    SH_ACK
  } shift_e;
endpackage

// File: rtl/lcdp_bus_sampler.sv
module lcdp_bus_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // SYNC synchronizer stages plus one history stage per line
  logic [SYNC:0] scl_q;
  logic [SYNC:0] sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC-1:0], scl_i};
      sda_q <= {sda_q[SYNC-1:0], sda_i};
    end
  end

  logic scl_p, sda_p;
  assign scl_s = scl_q[SYNC-1];
  assign sda_s = sda_q[SYNC-1];
  assign scl_p = scl_q[SYNC];
  assign sda_p = sda_q[SYNC];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/lcdp_byte_shifter.sv
module lcdp_byte_shifter
  import lcdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_q,
  output logic              ack_slot
);
  localparam int CNT_W = $clog2(BYTE_W);

  shift_e           st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st        <= SH_BITS;
      cnt       <= '0;
      byte_done <= 1'b0;
      byte_q    <= '0;
    end else begin
      byte_done <= 1'b0;
      case (st)
        SH_BITS: if (scl_rise) begin
          byte_q <= {byte_q[BYTE_W-2:0], sda_s};
          if (cnt == CNT_W'(BYTE_W - 1)) begin
            cnt       <= '0;
            st        <= SH_WAITF;
            byte_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SH_WAITF: if (scl_fall) st <= SH_ACK;
        SH_ACK:   if (scl_fall) st <= SH_BITS;
        default:  st <= SH_BITS;
      endcase
    end
  end

  assign ack_slot = (st == SH_ACK);
endmodule

// File: rtl/lcdp_disp_ram.sv
module lcdp_disp_ram #(
  parameter int DEPTH = 40,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] row [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (we && waddr == AW'(g)) row[g] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < DEPTH) ? row[raddr] : '0;
endmodule

// File: rtl/lcd_i2c_cmd_parser.sv
module lcd_i2c_cmd_parser
  import lcdp_pkg::*;
#(
  parameter int          DEPTH   = 40,
  parameter int          SYNC    = 2,
  parameter logic [5:0]  ADDR_HI = 6'b011100,
  localparam int         PTR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              sa0_strap,
  input  logic [SUB_W-1:0]  hw_sub,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  lcdp_bus_sampler #(.SYNC(SYNC)) u_samp (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_e             phase;
  logic               byte_done;
  logic [BYTE_W-1:0]  rx_byte;
  logic               ack_slot;
  logic               ack_hold;
  logic               shift_clr;
  logic [SUB_W-1:0]   sel_sub;
  logic [PTR_W-1:0]   ptr;

  assign shift_clr = start_det | stop_det | (phase == PH_IDLE);

  lcdp_byte_shifter u_shift (
    .clk(clk), .rst(rst), .clr(shift_clr),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .byte_done(byte_done), .byte_q(rx_byte), .ack_slot(ack_slot)
  );

  // byte decode
  logic addr_hit, sel_hit, is_sub_cmd, is_ptr_cmd, more_cmds, live_byte;
  logic [PTR_W-1:0] ptr_load;
  assign live_byte  = byte_done & ~start_det & ~stop_det;
  assign addr_hit   = (rx_byte[7:1] == {ADDR_HI, sa0_strap}) & ~rx_byte[0];
  assign sel_hit    = (sel_sub == hw_sub);
  assign is_sub_cmd = (rx_byte[6:5] == 2'b11) & (rx_byte[4:3] == 2'b10);
  assign is_ptr_cmd = (rx_byte[6:5] == 2'b00);
  assign more_cmds  = rx_byte[7];
  assign ptr_load   = (int'(rx_byte[4:0]) < DEPTH) ? PTR_W'(rx_byte[4:0]) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      ack_hold  <= 1'b0;
      sel_sub   <= '0;
      ptr       <= '0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (stop_det) begin
        phase    <= PH_IDLE;
        ack_hold <= 1'b0;
      end else if (start_det) begin
        phase    <= PH_ADDR;
        ack_hold <= 1'b0;
      end else if (byte_done) begin
        case (phase)
          PH_ADDR: begin
            ack_hold <= addr_hit;
            phase    <= addr_hit ? PH_CMD : PH_SKIP;
          end
          PH_CMD: begin
            ack_hold  <= 1'b1;
            cmd_valid <= 1'b1;
            cmd_byte  <= rx_byte;
            if (is_sub_cmd) sel_sub <= rx_byte[SUB_W-1:0];
            if (is_ptr_cmd) ptr <= ptr_load;
            if (!more_cmds) phase <= PH_DATA;
          end
          PH_DATA: begin
            ack_hold <= sel_hit;
            if (ptr == PTR_W'(DEPTH - 1)) begin
              ptr     <= '0;
              sel_sub <= sel_sub + 1'b1;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end
          default: ack_hold <= 1'b0;
        endcase
      end
    end
  end

  assign sda_oe = ack_slot & ack_hold;

  logic ram_we;
  assign ram_we = live_byte & (phase == PH_DATA) & sel_hit;

  lcdp_disp_ram #(.DEPTH(DEPTH), .W(BYTE_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ptr), .wdata(rx_byte),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/lcdp_checker.sv
module lcdp_checker
  import lcdp_pkg::*;
#(
  parameter int  DEPTH = 40,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input phase_e           phase,
  input logic [PTR_W-1:0] ptr,
  input logic             sda_oe,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             byte_done,
  input logic             cmd_valid
);
  logic data_step;
  assign data_step = byte_done & ~start_det & ~stop_det & (phase == PH_DATA);

  // R3: a skipped transfer never drives the line
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> !sda_oe);

  // R4: command beats come only out of the command phase
  a_r4_cmd_from_cmd_phase: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($past(phase) == PH_CMD));

  // R8: each data byte moves the pointer on by one (with wrap)
  a_r8_ptr_steps: assert property (@(posedge clk) disable iff (rst)
    data_step |=> (ptr == (($past(ptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(ptr) + 1'b1)));

  // R9: pointer stays inside the RAM
  a_r9_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(ptr) < DEPTH);

  // R12: STOP returns to idle with the line released
  a_r12_stop_idles: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (phase == PH_IDLE) && !sda_oe);

  // R13: acknowledge begins only after an SCL falling edge
  a_r13_ack_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
endmodule

bind lcd_i2c_cmd_parser lcdp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .ptr(ptr), .sda_oe(sda_oe),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .byte_done(byte_done), .cmd_valid(cmd_valid)
);

// File: tb/tb_lcd_i2c_cmd_parser.sv
module tb_lcd_i2c_cmd_parser;
  localparam int Q = 8; // clocks per quarter bit

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sa0 = 1'b0;
  logic [2:0] hw = 3'd0;
  logic [5:0] rd_addr = '0;
  logic       sda_oe, cmd_valid;
  logic [7:0] cmd_byte, rd_data;
  logic       sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  lcd_i2c_cmd_parser dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .sa0_strap(sa0), .hw_sub(hw), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0, n_bad = 0;
  int cmd_cnt = 0, wide_pulse = 0, oe_in_bits = 0;
  logic [7:0] last_cmd = '0;
  logic prev_valid = 1'b0;

  always @(negedge clk) begin
    if (cmd_valid) begin
      cmd_cnt++;
      last_cmd = cmd_byte;
      if (prev_valid) wide_pulse++;
    end
    prev_valid = cmd_valid;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw();
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw();
      scl_m = 1'b1; qw();
      if (sda_oe) oe_in_bits++;
      qw();
      scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    ack = ~sda_line;
    qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic send_exp(input logic [7:0] b, input bit exp, input string tag);
    bit a;
    send(b, a);
    chk(a == exp, tag, a, exp);
  endtask

  task automatic chk_ram(input int a, input logic [7:0] exp, input string tag);
    rd_addr = 6'(a);
    #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 oe low after reset", sda_oe, 0);
    chk(cmd_valid == 1'b0, "R1 no beat after reset", cmd_valid, 0);
  endtask

  task automatic t_basic();
    int c0 = cmd_cnt;
    bus_start();
    send_exp(8'h70, 1, "R2 address ack");
    send_exp(8'h60, 1, "R4 command ack");
    send_exp(8'hA1, 1, "R1 first data ack at sub 0");
    send_exp(8'hA2, 1, "R8 second data ack");
    bus_stop();
    chk(cmd_cnt == c0 + 1, "R4 one beat", cmd_cnt - c0, 1);
    chk(last_cmd == 8'h60, "R4 beat byte", last_cmd, 8'h60);
    chk_ram(0, 8'hA1, "R1 data at row 0");
    chk_ram(1, 8'hA2, "R8 pointer advanced");
  endtask

  task automatic t_addr_miss();
    int c0 = cmd_cnt;
    sa0 = 1'b1;
    bus_start();
    send_exp(8'h70, 0, "R3 wrong SA0 no ack");
    send_exp(8'h00, 0, "R3 command ignored");
    send_exp(8'h55, 0, "R3 data ignored");
    bus_stop();
    bus_start();
    send_exp(8'h72, 1, "R2 SA0=1 address ack");
    bus_stop();
    sa0 = 1'b0;
    bus_start();
    send_exp(8'h71, 0, "R3 read bit no ack");
    send_exp(8'h00, 0, "R3 read transfer ignored");
    bus_stop();
    chk(cmd_cnt == c0, "R3 no beats", cmd_cnt - c0, 0);
    chk_ram(0, 8'hA1, "R3 RAM untouched");
  endtask

  task automatic t_chain();
    int c0 = cmd_cnt;
    bus_start();
    send_exp(8'h70, 1, "R5 address");
    send_exp(8'h8A, 1, "R7 ptr 10 with C=1");
    send_exp(8'h05, 1, "R5 second command acked");
    send_exp(8'h3C, 1, "R5 data after C=0");
    bus_stop();
    chk(cmd_cnt == c0 + 2, "R5 two beats", cmd_cnt - c0, 2);
    chk(last_cmd == 8'h05, "R5 last beat", last_cmd, 8'h05);
    chk_ram(5, 8'h3C, "R7 data at loaded row");
  endtask

  task automatic t_subsel();
    hw = 3'd3;
    bus_start();
    send_exp(8'h70, 1, "R6 address");
    send_exp(8'hF3, 1, "R6 select sub 3");
    send_exp(8'h07, 1, "R6 ptr 7");
    send_exp(8'h77, 1, "R6 selected data ack");
    bus_stop();
    chk_ram(7, 8'h77, "R6 stored when selected");
    bus_start();
    send_exp(8'h70, 1, "R6 address again");
    send_exp(8'hF2, 1, "R6 select sub 2");
    send_exp(8'h07, 1, "R6 ptr 7 again");
    send_exp(8'h99, 0, "R10 unselected no ack");
    bus_stop();
    chk_ram(7, 8'h77, "R10 unselected not stored");
    hw = 3'd0;
  endtask

  task automatic t_unsel_advance();
    bus_start();
    send_exp(8'h70, 1, "R10 address");
    send_exp(8'hF1, 1, "R10 select sub 1");
    send_exp(8'h00, 1, "R10 ptr 0");
    send_exp(8'h11, 0, "R10 skip byte 0");
    send_exp(8'h22, 0, "R10 skip byte 1");
    bus_stop();
    bus_start();
    send_exp(8'h70, 1, "R10 address 2");
    send_exp(8'h70, 1, "R10 select sub 0 last cmd");
    send_exp(8'h33, 1, "R10 data acked");
    bus_stop();
    chk_ram(2, 8'h33, "R10 pointer advanced while unselected");
    chk_ram(0, 8'hA1, "R10 row 0 kept");
  endtask

  task automatic t_wrap();
    bus_start();
    send_exp(8'h70, 1, "R9 address");
    send_exp(8'hF0, 1, "R9 select sub 0");
    send_exp(8'h1E, 1, "R9 ptr 30");
    for (int i = 0; i < 10; i++) send_exp(8'hC0 + 8'(i), 1, "R9 run to row 39");
    send_exp(8'hEE, 0, "R9 after wrap sub 1 not ours");
    bus_stop();
    chk_ram(30, 8'hC0, "R9 row 30");
    chk_ram(39, 8'hC9, "R9 row 39");
    chk_ram(0, 8'hA1, "R9 wrapped byte not stored");
    hw = 3'd1;
    bus_start();
    send_exp(8'h70, 1, "R9 address as sub 1");
    send_exp(8'h60, 1, "R9 no-op command");
    send_exp(8'h5A, 1, "R9 sub 1 now selected");
    bus_stop();
    chk_ram(1, 8'h5A, "R9 continues at row 1");
    hw = 3'd0;
  endtask

  task automatic t_restart();
    int c0 = cmd_cnt;
    bus_start();
    send_exp(8'h70, 1, "R11 address");
    send_exp(8'hF0, 1, "R11 select sub 0");
    send_exp(8'h04, 1, "R11 ptr 4");
    send_exp(8'h44, 1, "R11 data");
    bus_restart();
    send_exp(8'h70, 1, "R11 address after Sr");
    send_exp(8'h08, 1, "R11 byte is a command");
    send_exp(8'h88, 1, "R11 data after Sr");
    bus_restart();
    sa0 = 1'b1;
    send_exp(8'h70, 0, "R11 mismatch after Sr");
    send_exp(8'h12, 0, "R11 rest ignored");
    sa0 = 1'b0;
    bus_stop();
    chk(cmd_cnt == c0 + 3, "R11 beat count", cmd_cnt - c0, 3);
    chk(last_cmd == 8'h08, "R11 last beat", last_cmd, 8'h08);
    chk_ram(4, 8'h44, "R11 row 4");
    chk_ram(8, 8'h88, "R11 row 8");
  endtask

  task automatic t_stop_idle();
    int c0 = cmd_cnt;
    scl_m = 1'b0; qw();
    send_exp(8'h70, 0, "R12 no ack without START");
    send_exp(8'h00, 0, "R12 still idle");
    chk(cmd_cnt == c0, "R12 no beats", cmd_cnt - c0, 0);
    scl_m = 1'b1; qw();
    chk(oe_in_bits == 0, "R13 oe during data bits", oe_in_bits, 0);
    chk(wide_pulse == 0, "R4 beat width", wide_pulse, 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_addr_miss();
    t_chain();
    t_subsel();
    t_unsel_advance();
    t_wrap();
    t_restart();
    t_stop_idle();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule